// File: doc/BRIEF.md
# Banked Inverted-Sense GPIO Register File

This block gives a register bus access to six 8-bit groups of general-purpose I/O lines. Each line works like an open-drain pin. A set bit in a port's data register turns on a pull-down and drives the line low. A clear bit turns the driver off, so an external pull-up holds the line high, and the line can then be used as an input. A read of a port does not return the stored value. It returns the level sensed at the pad after a two-flop synchronizer, inverted, so a 1 means the line is low.

A combined control register holds two fields. The low bits are a write-inhibit mask with one bit per port. The top two bits select the register bank. Port data registers respond only while bank 0 is selected. The control register can be reached in every bank. A write that tries to select the illegal bank code keeps the current bank and pulses an error output for one cycle. The mask bits from that same write still take effect.

Top module: `inv_gpio_bank`

## Requirements
- R1: After reset, every port data register is 0, so no pull-down is enabled. The mask is 0, the bank is 0, `bus_rdata` is 0 and `bank_err` is 0.
- R2: In bank 0, a write to address E0h+p (p = 0..5) stores the write data in port p's register. Bit n of that register drives `pad_pull_low[8*p+n]`, and a 1 enables the pull-down. The new value shows on the pin in the cycle after the write.
- R3: A read of port p returns the inverted synchronized pad levels. Bit n is 1 when `pad_in[8*p+n]` is low. A pad change shows in read data when the read is issued at least three clock edges after the change. The read follows the pad, not the stored bit.
- R4: The control register is at E6h. Bits 5:0 are the write-inhibit mask, bit p for port p. Bits 7:6 are the bank code. A read returns {bank, mask} in any bank.
- R5: While mask bit p is 1, a write to port p's address leaves that register and its pins unchanged. Writes to the other ports still take effect.
- R6: Writing bank code 00, 01 or 10 to bits 7:6 of E6h selects bank 0, 1 or 2.
- R7: A write of bank code 11 keeps the previous bank and still stores the mask bits. `bank_err` is 1 in the cycle after that write and 0 again in the next cycle, unless a second illegal write follows.
- R8: While bank 1 or bank 2 is selected, reads of E0h..E5h return 0 and writes to those addresses have no effect.
- R9: Read data is registered. It updates in the cycle after `bus_re` is high and holds its value when `bus_re` is low. A read of an address that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| bank_err | output | 1 | One-cycle pulse after an illegal bank write |
| pad_in | input | 48 | Sensed pad levels, port p at bits 8p+7..8p |
| pad_pull_low | output | 48 | Pull-down enables, 1 drives the line low |

## Verification
The assertions assume single-cycle strobes. They also assume a stable address and write data during each strobe, and that `bus_we` and `bus_re` are never high in the same cycle. The bench drives each strobe for exactly one cycle from the falling edge and never overlaps a read with a write. The bench models each pad as pulled low by the block's own driver or by an external source, and high otherwise. It always waits three cycles after any pad change before it issues a read, so every read sees settled synchronizer state.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        BANK_PORTS = 2'b00,
        BANK_ONE   = 2'b01,
        BANK_TWO   = 2'b10,
        BANK_BAD   = 2'b11
    } bank_e;

    function automatic logic bank_code_ok(input logic [1:0] code);
        return code != 2'b11;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = pad_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{meta: '1, stable: '1};
        end else begin
            s_q <= s_d;
        end
    end

    assign synced = s_q.stable;

endmodule

// File: rtl/gpio_port_reg.sv
module gpio_port_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         inhibit,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pull_low
);
    typedef struct packed {
        logic [W-1:0] data;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_hit && !inhibit) begin
            p_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pull_low = p_q.data;

    // R5
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && inhibit) |=> $stable(pull_low));

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !inhibit) |=> (pull_low == $past(wdata)));

endmodule

// File: rtl/gpio_ctrl_reg.sv
module gpio_ctrl_reg
    import gpio_pkg::*;
#(
    parameter int N_PORTS = 6,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [REG_W-1:0]   wdata,
    output logic [N_PORTS-1:0] mask,
    output bank_e              bank,
    output logic               bank_err
);
    localparam int BANK_LSB = REG_W - 2;

    typedef struct packed {
        logic [N_PORTS-1:0] mask;
        bank_e              bank;
        logic               err;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [1:0] code_in;

    assign code_in = wdata[BANK_LSB +: 2];

    always_comb begin
        c_d     = c_q;
        c_d.err = 1'b0;
        if (wr_hit) begin
            c_d.mask = wdata[N_PORTS-1:0];
            if (bank_code_ok(code_in)) begin
                c_d.bank = bank_e'(code_in);
            end else begin
                c_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{mask: '0, bank: BANK_PORTS, err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mask     = c_q.mask;
    assign bank     = c_q.bank;
    assign bank_err = c_q.err;

    // R7
    bad_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && code_in == 2'b11) |=> ($stable(bank) && bank_err));

    // R7
    mask_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (mask == $past(wdata[N_PORTS-1:0])));

    // R6
    good_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && code_in != 2'b11) |=> (bank == $past(code_in) && !bank_err));

endmodule

// File: rtl/inv_gpio_bank.sv
module inv_gpio_bank
    import gpio_pkg::*;
#(
    parameter int          N_PORTS   = 6,
    parameter int          PORT_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'hE0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [PORT_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    output logic [PORT_W-1:0]          bus_rdata,
    output logic                       bank_err,
    input  logic [N_PORTS*PORT_W-1:0]  pad_in,
    output logic [N_PORTS*PORT_W-1:0]  pad_pull_low
);
    localparam int                TOTAL_W   = N_PORTS * PORT_W;
    localparam logic [ADDR_W-1:0] PORT_BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_ADDR + N_PORTS);

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } top_t;

    top_t t_d, t_q;

    logic [TOTAL_W-1:0] pad_synced;
    logic [N_PORTS-1:0] inhibit;
    logic [N_PORTS-1:0] addr_is_port;
    logic               addr_is_ctrl;
    logic               ports_open;
    bank_e              bank_sel;

    assign addr_is_ctrl = (bus_addr == CTRL_ADDR);
    assign ports_open   = (bank_sel == BANK_PORTS);

    gpio_in_sync #(.W(TOTAL_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .synced (pad_synced)
    );

    gpio_ctrl_reg #(.N_PORTS(N_PORTS), .REG_W(PORT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (bus_we && addr_is_ctrl),
        .wdata    (bus_wdata),
        .mask     (inhibit),
        .bank     (bank_sel),
        .bank_err (bank_err)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign addr_is_port[p] = (bus_addr == PORT_BASE + ADDR_W'(p));

        gpio_port_reg #(.W(PORT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (bus_we && ports_open && addr_is_port[p]),
            .inhibit  (inhibit[p]),
            .wdata    (bus_wdata),
            .pull_low (pad_pull_low[p*PORT_W +: PORT_W])
        );
    end

    always_comb begin
        t_d = t_q;
        if (bus_re) begin
            t_d.rdata = '0;
            if (addr_is_ctrl) begin
                t_d.rdata[N_PORTS-1:0]     = inhibit;
                t_d.rdata[PORT_W-1 -: 2]   = bank_sel;
            end else if (ports_open) begin
                for (int p = 0; p < N_PORTS; p++) begin
                    if (addr_is_port[p]) begin
                        t_d.rdata = ~pad_synced[p*PORT_W +: PORT_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign bus_rdata = t_q.rdata;

    // R8
    closed_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (|addr_is_port) && bank_sel != BANK_PORTS) |=> (bus_rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R8
    closed_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (|addr_is_port) && bank_sel != BANK_PORTS) |=> $stable(pad_pull_low));

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |-> (pad_pull_low == '0 && bus_rdata == '0 && !bank_err));

endmodule

// File: tb/test_inv_gpio_bank.sv
module test_inv_gpio_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bank_err;
    logic [47:0] pad_in;
    logic [47:0] pad_pull_low;
    logic [47:0] ext_low = '0;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    logic  rd_pending = 1'b0;

    always #5 clk = ~clk;

    assign pad_in = ~(pad_pull_low | ext_low);

    inv_gpio_bank i_inv_gpio_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_rdata    (bus_rdata),
        .bank_err     (bank_err),
        .pad_in       (pad_in),
        .pad_pull_low (pad_pull_low)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) rd_pending <= bus_re;

    always @(negedge clk) begin
        if (rd_pending) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, 64'(bus_rdata), 64'(it.exp));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pull-downs off at reset", 64'(pad_pull_low), 64'd0);
        check("R1 rdata zero at reset", 64'(bus_rdata), 64'd0);
        check("R1 no error at reset", 64'(bank_err), 64'd0);
        rst_n = 1'b1;
        settle();
        bus_read(8'hE6, 8'h00, "R1 ctrl zero after reset");
        bus_read(8'hE0, 8'h00, "R3 released port reads zero");

        bus_write(8'hE0, 8'hA5);
        check("R2 port0 drive after write", 64'(pad_pull_low[7:0]), 64'hA5);
        settle();
        bus_read(8'hE0, 8'hA5, "R3 driven lines read one");
        bus_write(8'hE3, 8'h3C);
        check("R2 port3 drive", 64'(pad_pull_low[31:24]), 64'h3C);
        bus_write(8'hE3, 8'h00);
        check("R2 port3 release", 64'(pad_pull_low[31:24]), 64'h00);

        ext_low[42] = 1'b1;
        settle();
        bus_read(8'hE5, 8'h04, "R3 external low read while register zero");
        ext_low = '0;
        settle();

        bus_write(8'hE6, 8'h02);
        bus_write(8'hE1, 8'hFF);
        check("R5 masked port1 unchanged", 64'(pad_pull_low[15:8]), 64'h00);
        settle();
        bus_read(8'hE1, 8'h00, "R5 masked port1 reads released");
        bus_write(8'hE0, 8'h0F);
        check("R5 unmasked port0 still writable", 64'(pad_pull_low[7:0]), 64'h0F);
        bus_read(8'hE6, 8'h02, "R4 ctrl readback mask");

        bus_write(8'hE6, 8'h40);
        bus_read(8'hE6, 8'h40, "R6 bank1 selected");
        settle();
        bus_read(8'hE0, 8'h00, "R8 port read in bank1 zero");
        bus_write(8'hE2, 8'hFF);
        check("R8 port write in bank1 ignored", 64'(pad_pull_low[23:16]), 64'h00);
        bus_read(8'hE7, 8'h00, "R9 unmapped address reads zero");

        @(negedge clk);
        bus_addr  = 8'hE6;
        bus_wdata = 8'hC3;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        check("R7 error pulse high", 64'(bank_err), 64'd1);
        @(negedge clk);
        check("R7 error pulse ends", 64'(bank_err), 64'd0);
        bus_read(8'hE6, 8'h43, "R7 bank kept mask applied");

        bus_write(8'hE6, 8'h80);
        bus_read(8'hE6, 8'h80, "R6 bank2 selected");
        bus_read(8'hE4, 8'h00, "R8 port read in bank2 zero");
        bus_write(8'hE6, 8'h00);
        bus_read(8'hE0, 8'h0F, "R6 bank0 restores port access");
        repeat (3) @(negedge clk);
        check("R9 rdata holds without read", 64'(bus_rdata), 64'h0F);
        check("R2 other ports untouched", 64'(pad_pull_low[47:8]), 64'h0);

        repeat (2) @(negedge clk);
        check("scoreboard drained", 64'(sb_q.size()), 64'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule